// File: doc/BRIEF.md
# Pipelined Signed 4x4 Multiplier

This block multiplies two 4-bit two's complement operands and returns their 8-bit two's complement product. The multiplier bits select sign-extended, shifted copies of the multiplicand. Those partial products go into a two-level adder tree. At the first level, two adders run side by side. One adds the partial products for multiplier bits 0 and 1. The other subtracts the bit-3 partial product from the bit-2 partial product, because bit 3 of a two's complement number has negative weight. Both first-level sums are held in a register stage. At the second level, one adder combines the two held sums, offset by two bit places, and the result goes into an output register.

Operands are sampled on every rising clock edge. The block accepts a new operand pair each cycle, and each product appears a fixed two edges after its operands. Every adder is cut to the smallest width that can hold its value range. The upper first-level sum never stores its two low bits, because they are always zero. For the same reason, the final adder only works on the product bits above bit 1.

Top module: `smul4_pipe`

## Requirements
- R1: For every pair of signed operands in the range -8 to +7, the output `prod` equals the signed product `mcand * mplier`, as an 8-bit two's complement value.
- R2: Operands present at a rising edge k appear on `prod` just after rising edge k+1 (latency of two edges).
- R3: A different operand pair can be applied on every cycle, and each pair produces its own product in the order it was applied.
- R4: While `rst` (active high, synchronous) is sampled high, `prod` reads 0 after the edge. On the first edge after `rst` is released, `prod` still reads 0. On the second edge after release, `prod` shows the product of the operands from the first edge.
- R5: Multiplier bit 3 has weight -8. With `mplier` = 4'b1000 (-8), the product is -8 times `mcand`. The case -8 times -8 gives +64 (8'b0100_0000).
- R6: The first-level sums are 6 bits wide. The lower sum covers multiplier bits 0 and 1. The upper sum covers bits 2 and 3, holds no always-zero low bits, and enters the final adder shifted left by 2. A zero upper sum makes `prod` equal the sign-extended lower sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset that clears both pipeline stages |
| mcand | input | 4 | Multiplicand, two's complement |
| mplier | input | 4 | Multiplier, two's complement |
| prod | output | 8 | Product, two's complement, two edges behind the operands |

## Verification
An error in either first-level sum reaches `prod` one edge after it is held. It shows up as a wrong value whenever the faulty sum is non-zero. A sign or alignment fault in the upper sum affects only operand pairs with a multiplier bit 2 or 3 set. The exhaustive sweep over all 256 pairs, with its -8 cases, exposes such faults. A stage that fails to clear, or an off-by-one latency, makes `prod` carry the wrong pair's product in the cycle right after reset or during the streaming sweep.

// File: rtl/smul4_pkg.sv
package smul4_pkg;

    localparam int OP_W    = 4;
    localparam int PROD_W  = 2 * OP_W;
    localparam int PAIR_W  = OP_W + 2;
    localparam int ALIGN   = 2;
    localparam int N_PAIRS = OP_W / 2;

    typedef logic signed [OP_W-1:0]   op_t;
    typedef logic signed [PAIR_W-1:0] pair_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef struct packed {
        pair_t upper;   // bits 2,3 of the multiplier, weight 4
        pair_t lower;   // bits 0,1 of the multiplier, weight 1
    } pair_bus_t;

    function automatic pair_t widen_op(op_t v);
        return {{(PAIR_W-OP_W){v[OP_W-1]}}, v};
    endfunction

endpackage

// File: rtl/smul4_pair_adder.sv
module smul4_pair_adder
    import smul4_pkg::*;
#(
    parameter bit NEG_HI = 1'b0
) (
    input  op_t   op_i,
    input  logic  sel_lo,
    input  logic  sel_hi,
    output pair_t sum_o
);

    pair_t term_lo;
    pair_t term_hi;

    always_comb begin
        term_lo = sel_lo ? widen_op(op_i) : '0;
        term_hi = sel_hi ? pair_t'(widen_op(op_i) <<< 1) : '0;
    end

    generate
        if (NEG_HI) begin : g_sub
            assign sum_o = term_lo - term_hi;
        end else begin : g_add
            assign sum_o = term_lo + term_hi;
        end
    endgenerate

    always_comb begin
        if (!sel_lo && !sel_hi)
            AST_PAIR_GATED: assert (sum_o == '0); // R6
        if (sel_lo && !sel_hi)
            AST_PAIR_SINGLE: assert (sum_o == widen_op(op_i)); // R6
    end

endmodule

// File: rtl/smul4_stage.sv
module smul4_stage
    import smul4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pair_bus_t d_i,
    output pair_bus_t q_o
);

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
    end

    AST_STAGE_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> q_o == '0); // R4

    AST_STAGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q_o == $past(d_i)); // R2

endmodule

// File: rtl/smul4_final_adder.sv
module smul4_final_adder
    import smul4_pkg::*;
(
    input  pair_bus_t pp_i,
    output prod_t     sum_o
);

    localparam int TOP_W = PROD_W - ALIGN;

    logic signed [TOP_W-1:0] lower_top;
    logic signed [TOP_W-1:0] top_sum;

    always_comb begin
        lower_top = {{(TOP_W-(PAIR_W-ALIGN)){pp_i.lower[PAIR_W-1]}},
                     pp_i.lower[PAIR_W-1:ALIGN]};
        top_sum   = lower_top + TOP_W'(pp_i.upper);
        sum_o     = {top_sum, pp_i.lower[ALIGN-1:0]};
    end

    always_comb begin
        if (pp_i.upper == '0)
            AST_UPPER_ZERO: assert (sum_o == prod_t'(pp_i.lower)); // R6
    end

endmodule

// File: rtl/smul4_pipe.sv
module smul4_pipe
    import smul4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   mcand,
    input  logic [OP_W-1:0]   mplier,
    output logic [PROD_W-1:0] prod
);

    pair_t     pair_sum [N_PAIRS];
    pair_bus_t pp_d;
    pair_bus_t pp_q;
    prod_t     prod_d;

    generate
        for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
            smul4_pair_adder #(
                .NEG_HI (g == N_PAIRS - 1)
            ) u_pair (
                .op_i   (op_t'(mcand)),
                .sel_lo (mplier[2*g]),
                .sel_hi (mplier[2*g+1]),
                .sum_o  (pair_sum[g])
            );
        end
    endgenerate

    assign pp_d.lower = pair_sum[0];
    assign pp_d.upper = pair_sum[1];

    smul4_stage u_stage (
        .clk (clk),
        .rst (rst),
        .d_i (pp_d),
        .q_o (pp_q)
    );

    smul4_final_adder u_final (
        .pp_i  (pp_q),
        .sum_o (prod_d)
    );

    always_ff @(posedge clk) begin
        if (rst) prod <= '0;
        else     prod <= prod_d;
    end

    // assertion support: edges since reset release, saturating at 2
    logic [1:0] warm;
    prod_t      ref_prod;

    always_ff @(posedge clk) begin
        if (rst)              warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assign ref_prod = prod_t'($signed(mcand)) * prod_t'($signed(mplier));

    AST_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        warm == 2'd2 |-> prod == $past(ref_prod, 2)); // R1

    AST_OUT_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> prod == '0); // R4

    AST_NEG_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && $past(mplier, 2) == 4'b1000 && $past(mcand, 2) == 4'b1000)
        |-> prod == 8'sd64); // R5

endmodule

// File: tb/smul4_pipe_tb.sv
module smul4_pipe_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mcand = '0;
    logic [3:0] mplier = '0;
    logic [7:0] prod;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smul4_pipe u_dut (
        .clk    (clk),
        .rst    (rst),
        .mcand  (mcand),
        .mplier (mplier),
        .prod   (prod)
    );

    function automatic logic [7:0] ref_mul(logic [3:0] x, logic [3:0] y);
        int sx = $signed(x);
        int sy = $signed(y);
        int p  = sx * sy;
        return p[7:0];
    endfunction

    task automatic check(string req, logic [7:0] exp);
        checks++;
        if (prod !== exp) begin
            errors++;
            $display("FAIL %s: prod=%0d (0x%02h) expected %0d (0x%02h)",
                     req, $signed(prod), prod, $signed(exp), exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] prev_exp;
        repeat (3) tick();
        check("R4", 8'h00);                       // reset state

        // streaming sweep: pair n applied, pair n-1 checked (R1, R2, R3)
        mcand = 4'h3; mplier = 4'h5;
        rst = 1'b0;
        tick();
        check("R4", 8'h00);                       // first edge after release
        prev_exp = ref_mul(4'h3, 4'h5);
        for (int n = 0; n < 256; n++) begin
            mcand  = n[3:0];
            mplier = n[7:4];
            tick();
            check("R2", prev_exp);
            prev_exp = ref_mul(n[3:0], n[7:4]);
        end
        tick();
        check("R1", prev_exp);

        // reverse-order stream with alternating extremes (R3)
        for (int n = 15; n >= 0; n--) begin
            mcand  = n[3:0];
            mplier = ~n[3:0];
            tick();
            check("R3", prev_exp);
            prev_exp = ref_mul(n[3:0], ~n[3:0]);
        end

        // negative-weight multiplier bit (R5)
        for (int k = 0; k < 16; k++) begin
            mcand = k[3:0]; mplier = 4'b1000;
            tick(); tick();
            check("R5", ref_mul(k[3:0], 4'b1000));
        end
        mcand = 4'b1000; mplier = 4'b1000;
        tick(); tick();
        check("R5", 8'd64);

        // upper pair zero vs lower pair zero (R6)
        mcand = 4'b1001; mplier = 4'b0011;
        tick(); tick();
        check("R6", 8'hEB);                       // -7 * 3 = -21
        mcand = 4'b0111; mplier = 4'b0100;
        tick(); tick();
        check("R6", 8'd28);                       // 7 * 4
        mcand = 4'b0111; mplier = 4'b1100;
        tick(); tick();
        check("R6", 8'hE4);                       // 7 * -4 = -28

        // mid-stream reset (R4)
        mcand = 4'h7; mplier = 4'h7;
        tick(); tick();
        rst = 1'b1;
        tick();
        check("R4", 8'h00);
        mcand = 4'h6; mplier = 4'h5;
        rst = 1'b0;
        tick();
        check("R4", 8'h00);
        mcand = 4'h2; mplier = 4'h2;
        tick();
        check("R4", 8'd30);
        tick();
        check("R2", 8'd4);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule